// File: doc/BRIEF.md
# Stack Frame Prepare/Dispose Sequencer

This block builds and removes a procedure's stack frame over several cycles. A prepare saves a chosen subset of the twelve callee-saved registers r20 to r31 to memory below the stack pointer. It then lowers the stack pointer further to reserve a local area. A dispose does the reverse. It first releases the local area, then reloads the chosen registers and advances the stack pointer past them. If the jump field is nonzero, it also reports a branch target taken from a register once the reloads are finished.

The caller pulses `start` with the operation, the 12-bit list mask, the frame size in words, the jump field and the current stack pointer. The block drives a word-wide memory port with a request/ready handshake, plus the read and write ports of the register file. When the operation finishes it raises `done` for one cycle. In that cycle `sp_out` holds the new stack pointer, and `jump_taken` and `next_pc` hold the branch result. Instruction decode stays outside the block.

Top module: `frame_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `rf_we` and `jump_taken` are low, and no memory or register write happens while `busy` is low.
- R2: A prepare stores only registers whose mask bit is set, where bit i selects register 20+i. It walks from r20 upward. For each register it writes to SP-4 and then lowers SP by 4, so a lower-numbered register lands at a higher address.
- R3: A prepare ends with `sp_out` = `sp_in` - 4 x (number of set mask bits) - 4 x `frame_words`, and the frame subtraction comes after all stores.
- R4: A dispose first adds 4 x `frame_words` to SP. It then reloads the selected registers from r31 downward, each from the current SP, and raises SP by 4 after each load. The lowest-numbered register is therefore read from the highest address.
- R5: A dispose ends with `sp_out` = `sp_in` + 4 x `frame_words` + 4 x (number of set mask bits).
- R6: When a dispose's `jump_sel` is nonzero, `jump_taken` is high in the `done` cycle and `next_pc` equals register `jump_sel` as it stands after all reloads, so a just-restored register can be the target. When `jump_sel` is zero, `jump_taken` stays low.
- R7: A memory request is held with an unchanged address and write flag until `mem_ready` is high in the same cycle. Only then does the transfer count.
- R8: `done` is high for exactly one cycle per operation.
- R9: An empty mask causes no memory request and only the frame adjustment.
- R10: A `start` pulse while `busy` is high is ignored, and the running operation completes with its original arguments.
- R11: A dispose never writes memory, and a prepare never writes the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op_dispose | input | 1 | 0 = prepare, 1 = dispose |
| reg_mask | input | 12 | Bit i selects register 20+i |
| frame_words | input | 5 | Local frame size in words |
| jump_sel | input | 5 | Dispose jump register; 0 = no jump |
| sp_in | input | 32 | Stack pointer at start |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word address (byte units) |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Transfer accepted this cycle |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| sp_out | output | 32 | Current stack pointer, final value with done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| jump_taken | output | 1 | Dispose branch taken, valid with done |
| next_pc | output | 32 | Branch target, valid with jump_taken |

## Verification
The assertions assume three things about the environment. The register file answers reads in the same cycle. `mem_rdata` is valid whenever `mem_ready` is high. `mem_ready` is only raised in a cycle where a request is present. The bench's memory and register-file models are built to meet these: ready comes from a wait counter gated by `mem_req`, and read data is a direct array lookup. The stimulus only ever pulses `start` for a single cycle. A second pulse, given while an operation is running, is used to show that it is dropped. Stack pointers are kept well clear of address wrap-around.

// File: rtl/frame_pkg.sv
package frame_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RELEASE,
      ST_MOVE,
      ST_ALLOC,
      ST_JUMP,
      ST_DONE
   } seq_state_t;
endpackage

// File: rtl/frame_pick.sv
module frame_pick #(
   parameter int N         = 12,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  bits,
   output logic [IW-1:0] idx,
   output logic          any
);
   initial assert (N >= 2) else $error("frame_pick: N must be at least 2");

   assign any = |bits;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (bits[i]) idx = IW'(i);
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (bits[i]) idx = IW'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/frame_sp.sv
module frame_sp #(
   parameter int DATA_W  = 32,
   parameter int FRAME_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DATA_W-1:0]  load_val,
   input  logic               step_en,
   input  logic               step_down,
   input  logic               frame_en,
   input  logic               frame_down,
   input  logic [FRAME_W-1:0] frame_words,
   output logic [DATA_W-1:0]  sp
);
   localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(4);

   initial assert (DATA_W > FRAME_W + 2) else $error("frame_sp: DATA_W too small");

   logic [DATA_W-1:0] frame_bytes;
   assign frame_bytes = DATA_W'({frame_words, 2'b00});

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp <= '0;
      else if (load)
         sp <= load_val;
      else if (step_en)
         sp <= step_down ? sp - WORD_BYTES : sp + WORD_BYTES;
      else if (frame_en)
         sp <= frame_down ? sp - frame_bytes : sp + frame_bytes;
   end

   assert_sp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load) |=> (sp == $past(sp) + WORD_BYTES || sp == $past(sp) - WORD_BYTES));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
   import frame_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 12,
   parameter int BASE_REG = 20,
   parameter int FRAME_W  = 5,
   parameter int RIDX_W   = 5,
   localparam int IW      = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                op_dispose,
   input  logic [NUM_REGS-1:0] reg_mask,
   input  logic [FRAME_W-1:0]  frame_words,
   input  logic [RIDX_W-1:0]   jump_sel,
   input  logic [DATA_W-1:0]   sp_in,
   output logic                mem_req,
   output logic                mem_we,
   output logic [DATA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   input  logic                mem_ready,
   output logic [RIDX_W-1:0]   rf_raddr,
   input  logic [DATA_W-1:0]   rf_rdata,
   output logic                rf_we,
   output logic [RIDX_W-1:0]   rf_waddr,
   output logic [DATA_W-1:0]   rf_wdata,
   output logic [DATA_W-1:0]   sp_out,
   output logic                busy,
   output logic                done,
   output logic                jump_taken,
   output logic [DATA_W-1:0]   next_pc
);
   localparam logic [RIDX_W-1:0] BASE_IDX = RIDX_W'(BASE_REG);

   initial assert (BASE_REG + NUM_REGS <= 2 ** RIDX_W)
      else $error("frame_seq: register window exceeds index range");

   seq_state_t          state;
   logic                is_disp;
   logic [NUM_REGS-1:0] pend;
   logic [FRAME_W-1:0]  frame_q;
   logic [RIDX_W-1:0]   jsel_q;
   logic                jmp_q;
   logic [DATA_W-1:0]   pc_q;

   logic [IW-1:0] idx_lo, idx_hi, idx;
   logic          any_lo, any_hi;
   logic          xfer, accept, launch;
   logic [DATA_W-1:0] sp_cur;
   logic [RIDX_W-1:0] slot_reg;

   frame_pick #(.N(NUM_REGS), .LOW_FIRST(1'b1)) u_pick_up (
      .bits(pend), .idx(idx_lo), .any(any_lo));
   frame_pick #(.N(NUM_REGS), .LOW_FIRST(1'b0)) u_pick_down (
      .bits(pend), .idx(idx_hi), .any(any_hi));

   assign idx      = is_disp ? idx_hi : idx_lo;
   assign slot_reg = BASE_IDX + RIDX_W'(idx);
   assign launch   = (state == ST_IDLE) && start;
   assign xfer     = (state == ST_MOVE) && (is_disp ? any_hi : any_lo);
   assign accept   = xfer && mem_ready;

   frame_sp #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_sp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (launch),
      .load_val   (sp_in),
      .step_en    (accept),
      .step_down  (!is_disp),
      .frame_en   (state == ST_RELEASE || state == ST_ALLOC),
      .frame_down (state == ST_ALLOC),
      .frame_words(frame_q),
      .sp         (sp_cur)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_disp <= 1'b0;
         pend    <= '0;
         frame_q <= '0;
         jsel_q  <= '0;
         jmp_q   <= 1'b0;
         pc_q    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               is_disp <= op_dispose;
               pend    <= reg_mask;
               frame_q <= frame_words;
               jsel_q  <= jump_sel;
               jmp_q   <= 1'b0;
               state   <= op_dispose ? ST_RELEASE : ST_MOVE;
            end
            ST_RELEASE: state <= ST_MOVE;
            ST_MOVE: begin
               if (!xfer)
                  state <= !is_disp ? ST_ALLOC : ((jsel_q != '0) ? ST_JUMP : ST_DONE);
               else if (mem_ready)
                  pend[idx] <= 1'b0;
            end
            ST_ALLOC: state <= ST_DONE;
            ST_JUMP: begin
               pc_q  <= rf_rdata;
               jmp_q <= 1'b1;
               state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req    = xfer;
   assign mem_we     = xfer && !is_disp;
   assign mem_addr   = is_disp ? sp_cur : sp_cur - DATA_W'(4);
   assign mem_wdata  = rf_rdata;
   assign rf_raddr   = (state == ST_JUMP) ? jsel_q : slot_reg;
   assign rf_we      = accept && is_disp;
   assign rf_waddr   = slot_reg;
   assign rf_wdata   = mem_rdata;
   assign sp_out     = sp_cur;
   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_DONE);
   assign jump_taken = done && jmp_q;
   assign next_pc    = pc_q;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !rf_we && !jump_taken));
   assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_rf_only_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (mem_req && mem_ready && !mem_we));
   assert_pick_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> pend[idx]);
endmodule

// File: tb/tb_frame_seq.sv
module tb_frame_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op_dispose = 1'b0;
   logic [11:0] reg_mask = '0;
   logic [4:0]  frame_words = '0;
   logic [4:0]  jump_sel = '0;
   logic [31:0] sp_in = '0;
   logic        mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [4:0]  rf_raddr, rf_waddr;
   logic [31:0] rf_rdata, rf_wdata;
   logic        rf_we, busy, done, jump_taken;
   logic [31:0] sp_out, next_pc;

   logic [31:0] mem [64];
   logic [31:0] rf  [32];
   int ready_gap = 0;
   int wait_cnt = 0;
   int n_req = 0, n_memwr = 0, n_rfwr = 0, n_done = 0;
   int errors = 0, checks = 0;

   always #10 clk = ~clk;

   frame_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_dispose(op_dispose),
      .reg_mask(reg_mask), .frame_words(frame_words), .jump_sel(jump_sel),
      .sp_in(sp_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .sp_out(sp_out),
      .busy(busy), .done(done), .jump_taken(jump_taken), .next_pc(next_pc));

   assign mem_ready = mem_req && (wait_cnt >= ready_gap);
   assign mem_rdata = mem[mem_addr[7:2]];
   assign rf_rdata  = rf[rf_raddr];

   always @(posedge clk) begin
      if (mem_req && !mem_ready) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
      if (mem_req) n_req <= n_req + 1;
      if (mem_req && mem_ready && mem_we) begin
         mem[mem_addr[7:2]] <= mem_wdata;
         n_memwr <= n_memwr + 1;
      end
      if (rf_we) begin
         rf[rf_waddr] <= rf_wdata;
         n_rfwr <= n_rfwr + 1;
      end
      if (done) n_done <= n_done + 1;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int r);
      return 32'hA5000000 + (r << 8) + r;
   endfunction

   task automatic run_op(input bit disp, input logic [11:0] m, input logic [4:0] fw,
                         input logic [4:0] js, input logic [31:0] sp, input bit poke);
      @(negedge clk);
      n_req = 0; n_memwr = 0; n_rfwr = 0; n_done = 0;
      op_dispose = disp; reg_mask = m; frame_words = fw; jump_sel = js; sp_in = sp;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         @(negedge clk);
         op_dispose = ~disp; reg_mask = 12'hFFF; frame_words = 5'd31;
         jump_sel = 5'd1; sp_in = 32'h0000_0200;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int k = 0; k < 400 && !done; k++) @(negedge clk);
      check(done == 1'b1, "R8 done reached", {31'b0, done}, 32'd1);
   endtask

   task automatic t_reset;
      check(!busy && !done && !mem_req && !rf_we && !jump_taken, "R1 reset idle",
            {27'b0, busy, done, mem_req, rf_we, jump_taken}, 32'd0);
   endtask

   task automatic t_prepare_full;
      for (int r = 20; r < 32; r++) rf[r] = pat(r);
      ready_gap = 0;
      run_op(1'b0, 12'hFFF, 5'd3, 5'd0, 32'h0000_0080, 1'b0);
      check(sp_out == 32'h80 - 48 - 12, "R3 full prepare sp", sp_out, 32'h80 - 60);
      for (int i = 0; i < 12; i++) begin
         logic [31:0] a = 32'h80 - 4 * (i + 1);
         check(mem[a[7:2]] == pat(20 + i), "R2 store order", mem[a[7:2]], pat(20 + i));
      end
      check(n_rfwr == 0, "R11 prepare no rf write", n_rfwr, 0);
      @(negedge clk);
      check(!done && n_done == 1, "R8 single done", n_done, 1);
   endtask

   task automatic t_prepare_sparse;
      for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD0000 + i;
      ready_gap = 2;
      run_op(1'b0, 12'h805, 5'd1, 5'd0, 32'h0000_0080, 1'b0);
      check(sp_out == 32'h80 - 12 - 4, "R3 sparse prepare sp", sp_out, 32'h70);
      check(mem[6'h1F] == pat(20), "R2 r20 highest", mem[6'h1F], pat(20));
      check(mem[6'h1E] == pat(22), "R2 r22 next", mem[6'h1E], pat(22));
      check(mem[6'h1D] == pat(31), "R2 r31 lowest", mem[6'h1D], pat(31));
      check(mem[6'h1C] == 32'hDEAD001C, "R2 unselected untouched", mem[6'h1C], 32'hDEAD001C);
      check(n_memwr == 3, "R2 store count", n_memwr, 3);
      check(n_req == 9, "R7 request held for wait", n_req, 9);
   endtask

   task automatic t_prepare_empty;
      ready_gap = 0;
      run_op(1'b0, 12'h000, 5'd5, 5'd0, 32'h0000_0080, 1'b0);
      check(sp_out == 32'h80 - 20, "R9 empty prepare sp", sp_out, 32'h6C);
      check(n_req == 0, "R9 no request", n_req, 0);
   endtask

   task automatic t_dispose_sparse;
      mem[6'h12] = 32'h1111_0030; mem[6'h13] = 32'h2222_0025; mem[6'h14] = 32'h3333_0021;
      for (int r = 20; r < 32; r++) rf[r] = 32'h0;
      ready_gap = 1;
      run_op(1'b1, 12'h422, 5'd2, 5'd0, 32'h0000_0040, 1'b0);
      check(sp_out == 32'h54, "R5 dispose sp", sp_out, 32'h54);
      check(rf[30] == 32'h1111_0030, "R4 r30 from lowest", rf[30], 32'h1111_0030);
      check(rf[25] == 32'h2222_0025, "R4 r25 middle", rf[25], 32'h2222_0025);
      check(rf[21] == 32'h3333_0021, "R4 r21 from highest", rf[21], 32'h3333_0021);
      check(rf[22] == 32'h0, "R4 unselected untouched", rf[22], 32'h0);
      check(jump_taken == 1'b0, "R6 no jump when field zero", {31'b0, jump_taken}, 0);
      check(n_memwr == 0, "R11 dispose no store", n_memwr, 0);
   endtask

   task automatic t_round_trip_jump;
      for (int r = 20; r < 32; r++) rf[r] = pat(r) ^ 32'h00F0_0000;
      ready_gap = 2;
      run_op(1'b0, 12'hFFF, 5'd4, 5'd0, 32'h0000_00C0, 1'b0);
      check(sp_out == 32'h80, "R3 round trip prepare sp", sp_out, 32'h80);
      for (int r = 20; r < 32; r++) rf[r] = 32'h0;
      run_op(1'b1, 12'hFFF, 5'd4, 5'd31, 32'h0000_0080, 1'b0);
      check(sp_out == 32'hC0, "R5 round trip dispose sp", sp_out, 32'hC0);
      check(jump_taken == 1'b1, "R6 jump taken", {31'b0, jump_taken}, 1);
      check(next_pc == (pat(31) ^ 32'h00F0_0000), "R6 target is restored reg", next_pc, pat(31) ^ 32'h00F0_0000);
      for (int r = 20; r < 32; r++)
         check(rf[r] == (pat(r) ^ 32'h00F0_0000), "R4 restore value", rf[r], pat(r) ^ 32'h00F0_0000);
   endtask

   task automatic t_jump_other;
      rf[5] = 32'h1234_5678;
      ready_gap = 0;
      run_op(1'b1, 12'h000, 5'd0, 5'd5, 32'h0000_0040, 1'b0);
      check(jump_taken && next_pc == 32'h1234_5678, "R6 jump via r5", next_pc, 32'h1234_5678);
      check(sp_out == 32'h40 && n_req == 0, "R9 empty dispose", sp_out, 32'h40);
   endtask

   task automatic t_start_busy;
      for (int r = 20; r < 32; r++) rf[r] = pat(r);
      ready_gap = 3;
      run_op(1'b0, 12'h003, 5'd0, 5'd0, 32'h0000_0080, 1'b1);
      check(sp_out == 32'h78, "R10 start while busy ignored", sp_out, 32'h78);
      check(n_memwr == 2 && n_rfwr == 0, "R10 transfers unchanged", n_memwr, 2);
      repeat (3) @(negedge clk);
      check(!busy && n_done == 1, "R10 no second run", {31'b0, busy}, 0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) rf[i] = '0;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prepare_full();
      t_prepare_sparse();
      t_prepare_empty();
      t_dispose_sparse();
      t_round_trip_jump();
      t_jump_other();
      t_start_busy();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule